// File: doc/BRIEF.md
# Single-Wire Auto-Baud Debug Serial Port

This block is a half-duplex asynchronous serial transceiver for a debug port that uses a single shared pin. It has no programmed divisor. After reset it waits for the host to start talking. The first character the host sends is a fixed sync character, 0x80. The block counts system clocks across that character's low stretch and derives the bit period from the count. From then on it uses that bit period to receive host characters and to send its own replies on the same wire.

The pin is open-drain. The block never drives a high level. It asserts an output enable to pull the line low and releases it otherwise. Received bytes come out as a one-cycle valid pulse with the data. A byte whose stop bit reads low raises a framing-error pulse instead, and the byte is discarded. Bytes to transmit are accepted through a valid/ready pair. The ready signal rises as soon as an incoming stop bit has been sampled, so a reply can start immediately.

Top module: `swire_autobaud_uart`

## Requirements
- R1: A character on the wire is one low start bit, then eight data bits with bit 0 first, then one high stop bit. A received character with a high stop bit produces exactly one `rx_valid_o` pulse, with the byte on `rx_data_o`.
- R2: Out of reset, `locked_o` and `tx_ready_o` are low and `pin_oe_o` is released. They stay that way until a sync character has been accepted.
- R3: The block counts L, the number of consecutive clocks the synchronised pin stays low from the first falling edge. If L is accepted, `locked_o` rises, `bit_per_o` becomes L/8 (rounded down), and that value holds until reset.
- R4: A low stretch with L below 8*MIN_BIT is rejected. The block stays unlocked and waits for a new falling edge. L equal to 8*MIN_BIT is accepted.
- R5: If the low stretch keeps the counter at its all-ones value (2^CNT_W - 1) for one more low clock, the measurement is rejected and the block stays unlocked. L equal to 2^CNT_W - 1 is still accepted.
- R6: Each received bit is sampled near its middle: about half a period after the detected start edge, and then once every whole period. Host characters sent at the measured bit period are decoded correctly across the whole accepted range.
- R7: If a received stop bit is sampled low, there is one `frame_err_o` pulse and no `rx_valid_o`. `rx_valid_o` and `frame_err_o` are never high together.
- R8: After a transfer is accepted on `tx_valid_i`/`tx_ready_o`, the block sends start, data (bit 0 first) and stop. Each bit lasts exactly `bit_per_o` clocks. `pin_oe_o` is high only during low bits, beginning the cycle after acceptance.
- R9: `tx_ready_o` is high in the same cycle as the `rx_valid_o` pulse of a received character. This lets a reply begin while the host's stop bit is still on the wire.
- R10: While the block is transmitting, the receiver ignores the pin. Its own transmission produces no `rx_valid_o` or `frame_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Level sampled from the shared debug pin |
| pin_oe_o | output | 1 | 1 pulls the pin low; 0 releases it |
| rx_valid_o | output | 1 | One-cycle pulse: a received byte is on rx_data_o |
| rx_data_o | output | 8 | Last received byte |
| frame_err_o | output | 1 | One-cycle pulse: a received stop bit was low |
| tx_valid_i | input | 1 | Request to send tx_data_i |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | The block can accept a byte this cycle |
| locked_o | output | 1 | A bit period has been measured |
| bit_per_o | output | CNT_W-3 | Measured bit period in clocks |

## Verification
The bench builds the block with CNT_W = 10 and MIN_BIT = 8. This gives an accepted low stretch of 64 to 1023 clocks. Both rejection edges therefore take only about a thousand clocks to reach. The bench steps through bit periods from 8 to 127 with different remainders below a multiple of eight. It also pushes all 256 byte values through the receiver at the fastest period, and checks transmit waveforms clock by clock against a frame computed from the byte.

// File: rtl/swire_autobaud_uart.sv
module swire_autobaud_uart #(
  parameter int CNT_W   = 16,
  parameter int MIN_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  output logic             pin_oe_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic             frame_err_o,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_ready_o,
  output logic             locked_o,
  output logic [CNT_W-4:0] bit_per_o
);
  localparam int PER_W = CNT_W - 3;
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BIT * 8);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_MEAS, S_READY, S_RX, S_TX} st_t;

  st_t              st;
  logic             meta, pin_s, pin_d;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [9:0]       sh;
  logic [PER_W-1:0] per;
  logic             rx_valid, ferr;
  logic [7:0]       rx_data;

  wire              fall    = pin_d & ~pin_s;
  wire              tz      = (cnt == '0);
  wire [CNT_W-1:0]  per_ext = {3'b000, per};
  wire [CNT_W-1:0]  half    = per_ext >> 1;

  assign tx_ready_o  = (st == S_READY) & ~fall;
  assign locked_o    = (st == S_READY) | (st == S_RX) | (st == S_TX);
  assign pin_oe_o    = (st == S_TX) & ~sh[0];
  assign rx_valid_o  = rx_valid;
  assign rx_data_o   = rx_data;
  assign frame_err_o = ferr;
  assign bit_per_o   = per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      meta     <= 1'b1;
      pin_s    <= 1'b1;
      pin_d    <= 1'b1;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '1;
      per      <= '0;
      rx_valid <= 1'b0;
      ferr     <= 1'b0;
      rx_data  <= '0;
    end else begin
      meta     <= pin_i;
      pin_s    <= meta;
      pin_d    <= pin_s;
      rx_valid <= 1'b0;
      ferr     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (fall) begin
            cnt <= CNT_W'(1);
            st  <= S_MEAS;
          end
        end
        S_MEAS: begin
          if (!pin_s) begin
            if (cnt == CNT_MAX) st <= S_IDLE;
            else                cnt <= cnt + 1'b1;
          end else if (cnt < MIN_CNT) begin
            st <= S_IDLE;
          end else begin
            per <= cnt[CNT_W-1:3];
            st  <= S_READY;
          end
        end
        S_READY: begin
          if (fall) begin
            cnt  <= half;
            bitn <= '0;
            st   <= S_RX;
          end else if (tx_valid_i) begin
            sh   <= {1'b1, tx_data_i, 1'b0};
            cnt  <= per_ext - 1'b1;
            bitn <= '0;
            st   <= S_TX;
          end
        end
        S_RX: begin
          if (!tz) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt  <= per_ext - 1'b1;
            bitn <= bitn + 1'b1;
            if (bitn == 4'd0) begin
              if (pin_s) st <= S_READY;
            end else if (bitn == 4'd9) begin
              st <= S_READY;
              if (pin_s) begin
                rx_valid <= 1'b1;
                rx_data  <= sh[7:0];
              end else begin
                ferr <= 1'b1;
              end
            end else begin
              sh[7:0] <= {pin_s, sh[7:1]};
            end
          end
        end
        S_TX: begin
          if (!tz) begin
            cnt <= cnt - 1'b1;
          end else if (bitn == 4'd9) begin
            st <= S_READY;
          end else begin
            sh   <= {1'b1, sh[9:1]};
            bitn <= bitn + 1'b1;
            cnt  <= per_ext - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (!pin_oe_o && !rx_valid_o && !tx_ready_o));

  p_period_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && $past(locked_o)) |-> $stable(bit_per_o));

  p_period_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (int'(bit_per_o) >= MIN_BIT));

  p_rx_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && frame_err_o));

  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !pin_oe_o);

  p_ready_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> locked_o);

  p_no_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |=> (!rx_valid_o && !frame_err_o));
endmodule

// File: tb/test_swire_autobaud_uart.sv
module test_swire_autobaud_uart;
  localparam int CNT_W   = 10;
  localparam int MIN_BIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic pin_oe, rx_valid, frame_err, tx_ready, locked;
  logic [7:0] rx_data;
  logic [CNT_W-4:0] bit_per;
  wire line = !(host_low || pin_oe);

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0, err_cnt = 0;
  logic [7:0] rx_last = '0;
  logic rdy_at_valid = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swire_autobaud_uart #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) i_swire_autobaud_uart (
    .clk(clk), .rst_n(rst_n), .pin_i(line), .pin_oe_o(pin_oe),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .frame_err_o(frame_err),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .locked_o(locked), .bit_per_o(bit_per));

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
      rdy_at_valid = tx_ready;
    end
    if (frame_err) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    host_low = 1'b0;
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_sync(input int low_len, input int h);
    host_low = 1'b1;
    repeat (low_len) @(negedge clk);
    host_low = 1'b0;
    repeat (3 * h + 4) @(negedge clk);
  endtask

  task automatic host_send(input logic [7:0] d, input int h, input bit bad_stop);
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = (i == 0) ? 1'b0 : (i == 9) ? !bad_stop : d[i-1];
      host_low = !b;
      repeat (h) @(negedge clk);
    end
    host_low = 1'b0;
    repeat (h) @(negedge clk);
  endtask

  task automatic check_rx(input logic [7:0] d, input int h);
    int rc, ec;
    rc = rx_cnt;
    ec = err_cnt;
    host_send(d, h, 1'b0);
    chk(rx_cnt == rc + 1 && err_cnt == ec, "R6 one byte per frame", rx_cnt - rc, 1);
    chk(rx_last == d, "R1 received data", rx_last, d);
  endtask

  task automatic check_tx(input logic [7:0] d, input int h);
    logic [9:0] fr;
    int miss, rc, ec;
    fr = {1'b1, d, 1'b0};
    miss = 0;
    rc = rx_cnt;
    ec = err_cnt;
    while (!tx_ready) @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < 10 * h; i++) begin
      if (pin_oe !== !fr[i / h]) miss++;
      @(negedge clk);
    end
    chk(miss == 0, "R8 transmit waveform", miss, 0);
    repeat (4) @(negedge clk);
    chk(rx_cnt == rc && err_cnt == ec, "R10 no echo", rx_cnt + err_cnt, rc + ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hs[9];
    hs = '{8, 9, 10, 13, 16, 25, 40, 64, 127};

    do_reset();
    chk(!locked && !tx_ready && !pin_oe, "R2 reset state", {locked, tx_ready, pin_oe}, 0);

    // R4: one clock short of the minimum, then exactly the minimum
    host_sync(8 * MIN_BIT - 1, 8);
    chk(!locked && !tx_ready, "R4 short sync rejected", locked, 0);
    host_sync(8 * MIN_BIT, 8);
    chk(locked && bit_per == MIN_BIT, "R4 minimum sync accepted", bit_per, MIN_BIT);

    // R5: counter limit
    do_reset();
    host_sync((1 << CNT_W), 127);
    chk(!locked, "R5 overflow rejected", locked, 0);
    host_sync((1 << CNT_W) - 1, 127);
    chk(locked && bit_per == 127, "R5 all-ones accepted", bit_per, 127);

    // R3 / R6 / R8 / R9 sweep over bit periods and remainders
    foreach (hs[k]) begin
      int h, l;
      h = hs[k];
      l = 8 * h + (h % 8);
      do_reset();
      host_sync(l, h);
      chk(locked && int'(bit_per) == l / 8, "R3 measured period", bit_per, l / 8);
      for (int j = 0; j < 3; j++) check_rx(8'((h * 37 + j * 71) & 255), h);
      chk(rdy_at_valid, "R9 ready at stop sample", rdy_at_valid, 1);
      check_tx(8'((h * 29 + 90) & 255), h);
      check_tx(8'((h * 13 + 5) & 255), h);
      check_rx(8'((h * 7 + 200) & 255), h);
    end

    // R1: every byte value at the fastest period
    do_reset();
    host_sync(64, 8);
    for (int v = 0; v < 256; v++) check_rx(8'(v), 8);

    // R7: stop bit held low
    begin
      int rc, ec;
      rc = rx_cnt;
      ec = err_cnt;
      host_send(8'h5A, 8, 1'b1);
      repeat (8) @(negedge clk);
      chk(err_cnt == ec + 1 && rx_cnt == rc, "R7 framing error", err_cnt - ec, 1);
      check_rx(8'hC3, 8);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule